// File: doc/BRIEF.md
# Broadcast Range Fan-out and Reply Merger

This block sits in one switch element of a four-way fat tree and handles broadcasts addressed to a contiguous, inclusive range of destination numbers. The element serves an aligned block of 4^LEVEL destinations that starts at `sub_base`. Each of its four down ports leads to one quarter of that block. When a broadcast request arrives, the block decides between two outcomes. If the range lies entirely inside the element's block, the packet is copied downward to every port whose quarter touches the range. Otherwise it is passed further up the tree.

After a downward copy, the block waits for one reply from each port it copied to. It then issues a single merged reply on the return path. The merged reply is positive only when every copy was acknowledged positively. A silent port ends the wait after a fixed number of cycles and forces a negative result. Replies that are not expected, either because they come from a port that got no copy or because they repeat a reply already recorded, change nothing except a saturating error count. Only one downward broadcast may be in progress at a time, and new requests are held off until its merged reply has gone out.

Top module: `bcast_combiner`

## Requirements
- R1: After reset, `bc_ready` is 1, `up_go`, `down_go` and `rep_valid` are 0, and `err_cnt` is 0.
- R2: A request accepted on a clock edge (`bc_valid` and `bc_ready`) counts as covered when lo <= hi, lo >= `sub_base` and hi <= `sub_base` + 4^LEVEL - 1. In the next cycle a covered request raises `down_go` for one cycle with `up_go` low. Any other request raises `up_go` for one cycle with `down_go` low and leaves `bc_ready` at 1.
- R3: With `down_go`, bit i of `down_mask` (i = 0..3) is 1 exactly when the inclusive range [`sub_base` + i*4^(LEVEL-1), `sub_base` + (i+1)*4^(LEVEL-1) - 1] overlaps [lo, hi].
- R4: From the `down_go` cycle until the merged reply cycle, `bc_ready` is 0. A request presented in that time is neither forwarded upward nor copied downward.
- R5: A reply on port i is taken in a cycle where `ack_vld[i]` is 1, with `ack_ok[i]` = 1 meaning success. When the last expected reply is taken, `rep_valid` is 1 for exactly one cycle in the following cycle. `rep_ok` is 1 in that cycle if every taken reply was a success.
- R6: If any expected reply carries `ack_ok` = 0, the merged reply has `rep_ok` = 0.
- R7: Take the `down_go` cycle as wait cycle 0. Replies are taken in wait cycles 0 to TMO-1. If they are not all in by then, `rep_valid` rises in wait cycle TMO with `rep_ok` = 0. A last reply taken in wait cycle TMO-1 still gives the normal result.
- R8: A reply from a port outside `down_mask`, a repeated reply, and any reply while nothing is pending all leave the merged result unchanged. Each one adds 1 to `err_cnt`, and `err_cnt` saturates at 2^ERR_W - 1.
- R9: `bc_ready` is 1 in the merged reply cycle, so a request presented in that cycle is accepted at the edge that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_base | input | ID_W | First destination number served below this element, aligned to 4^LEVEL |
| bc_valid | input | 1 | Broadcast request present |
| bc_lo | input | ID_W | Lowest destination of the range |
| bc_hi | input | ID_W | Highest destination of the range |
| bc_ready | output | 1 | Request may be accepted (no broadcast pending) |
| up_go | output | 1 | One-cycle pulse: forward the request upward |
| down_go | output | 1 | One-cycle pulse: copy the packet downward |
| down_mask | output | 4 | Down ports that receive a copy, valid with down_go |
| ack_vld | input | 4 | Per-port reply strobe |
| ack_ok | input | 4 | Per-port reply status, 1 = success |
| rep_valid | output | 1 | One-cycle merged reply strobe |
| rep_ok | output | 1 | Merged reply status, 1 = every copy succeeded |
| err_cnt | output | ERR_W | Saturating count of ignored replies |

## Verification
Two pairs of events can land in the same cycle. In the first, the last expected reply arrives in wait cycle TMO-1, the same cycle in which the timeout would fire. A directed case delays a single-port copy by exactly that many cycles and expects a positive reply in wait cycle TMO. In the second, stray or repeated replies arrive alongside genuine ones. The randomized runs do this on purpose, with per-port delays, duplicates and replies on uncopied ports, and a bench model predicts both the merged result and the error count cycle by cycle.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   localparam int NPORT = 4;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } bcc_state_e;
endpackage

// File: rtl/bcc_range_decode.sv
module bcc_range_decode #(
   parameter int ID_W  = 8,
   parameter int LEVEL = 2
) (
   input  logic [ID_W-1:0]            base,
   input  logic [ID_W-1:0]            lo,
   input  logic [ID_W-1:0]            hi,
   output logic                       covered,
   output logic [bcc_pkg::NPORT-1:0]  mask
);
   localparam int SPAN_SH = 2 * LEVEL;
   localparam int QTR_SH  = 2 * (LEVEL - 1);
   localparam logic [ID_W:0] ONE  = {{ID_W{1'b0}}, 1'b1};
   localparam logic [ID_W:0] SPAN = ONE << SPAN_SH;
   localparam logic [ID_W:0] QTR  = ONE << QTR_SH;

   generate
      if (LEVEL < 1 || SPAN_SH > ID_W) begin : g_bad_level
         $error("bcc_range_decode: LEVEL must be >= 1 and 2*LEVEL <= ID_W");
      end
   endgenerate

   logic [ID_W:0] b_x, lo_x, hi_x, top_x;
   logic          ordered;

   assign b_x     = {1'b0, base};
   assign lo_x    = {1'b0, lo};
   assign hi_x    = {1'b0, hi};
   assign top_x   = b_x + SPAN - ONE;
   assign ordered = (lo_x <= hi_x);
   assign covered = ordered && (lo_x >= b_x) && (hi_x <= top_x);

   generate
      for (genvar i = 0; i < bcc_pkg::NPORT; i++) begin : g_port
         localparam logic [ID_W:0] OFF = (ID_W + 1)'(i) << QTR_SH;
         logic [ID_W:0] p_lo, p_hi;
         assign p_lo    = b_x + OFF;
         assign p_hi    = p_lo + QTR - ONE;
         assign mask[i] = ordered && (lo_x <= p_hi) && (hi_x >= p_lo);
      end
   endgenerate
endmodule

// File: rtl/bcc_ack_tracker.sv
module bcc_ack_tracker #(
   parameter int ERR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       active,
   input  logic [bcc_pkg::NPORT-1:0]  mask,
   input  logic [bcc_pkg::NPORT-1:0]  ack_vld,
   input  logic [bcc_pkg::NPORT-1:0]  ack_ok,
   output logic                       done_next,
   output logic                       nak_next,
   output logic [ERR_W-1:0]           err_cnt
);
   localparam int NP = bcc_pkg::NPORT;
   localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

   generate
      if (ERR_W < 3) begin : g_bad_err
         $error("bcc_ack_tracker: ERR_W must be at least 3");
      end
   endgenerate

   logic [NP-1:0]  rcv_q, take, stray, rcv_next;
   logic           nak_q;
   logic [ERR_W:0] err_sum;

   assign take      = active ? (ack_vld & mask & ~rcv_q) : '0;
   assign stray     = ack_vld & ~take;
   assign rcv_next  = rcv_q | take;
   assign done_next = active && (rcv_next == mask);
   assign nak_next  = nak_q || |(take & ~ack_ok);
   assign err_sum   = {1'b0, err_cnt} + (ERR_W + 1)'($countones(stray));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcv_q   <= '0;
         nak_q   <= 1'b0;
         err_cnt <= '0;
      end else begin
         if (clear) begin
            rcv_q <= '0;
            nak_q <= 1'b0;
         end else if (active) begin
            rcv_q <= rcv_next;
            nak_q <= nak_next;
         end
         err_cnt <= err_sum[ERR_W] ? ERR_MAX : err_sum[ERR_W-1:0];
      end
   end

   assert_err_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt >= $past(err_cnt));
   assert_rcv_in_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((rcv_q & ~mask) == '0));
endmodule

// File: rtl/bcc_timer.sv
module bcc_timer #(
   parameter int TMO = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expire
);
   localparam int TW = (TMO > 2) ? $clog2(TMO) : 1;

   generate
      if (TMO < 2) begin : g_bad_tmo
         $error("bcc_timer: TMO must be at least 2");
      end
   endgenerate

   logic [TW-1:0] tmr;

   assign expire = run && (tmr == TW'(TMO - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      tmr <= '0;
      else if (clear)  tmr <= '0;
      else if (run && !expire) tmr <= tmr + 1'b1;
   end

   assert_tmr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (32'(tmr) < TMO));
endmodule

// File: rtl/bcast_combiner.sv
module bcast_combiner #(
   parameter int ID_W  = 8,
   parameter int LEVEL = 2,
   parameter int TMO   = 32,
   parameter int ERR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   sub_base,
   input  logic              bc_valid,
   input  logic [ID_W-1:0]   bc_lo,
   input  logic [ID_W-1:0]   bc_hi,
   output logic              bc_ready,
   output logic              up_go,
   output logic              down_go,
   output logic [3:0]        down_mask,
   input  logic [3:0]        ack_vld,
   input  logic [3:0]        ack_ok,
   output logic              rep_valid,
   output logic              rep_ok,
   output logic [ERR_W-1:0]  err_cnt
);
   import bcc_pkg::*;

   bcc_state_e  state;
   logic        covered, accept, start, done_next, nak_next, expire;
   logic [3:0]  mask_c, mask_q;

   bcc_range_decode #(.ID_W(ID_W), .LEVEL(LEVEL)) u_dec (
      .base(sub_base), .lo(bc_lo), .hi(bc_hi),
      .covered(covered), .mask(mask_c)
   );

   assign bc_ready  = (state == ST_IDLE);
   assign accept    = bc_valid && bc_ready;
   assign start     = accept && covered;
   assign down_mask = mask_q;

   bcc_ack_tracker #(.ERR_W(ERR_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .clear(start), .active(state == ST_WAIT),
      .mask(mask_q), .ack_vld(ack_vld), .ack_ok(ack_ok),
      .done_next(done_next), .nak_next(nak_next), .err_cnt(err_cnt)
   );

   bcc_timer #(.TMO(TMO)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(start), .run(state == ST_WAIT),
      .expire(expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mask_q    <= '0;
         up_go     <= 1'b0;
         down_go   <= 1'b0;
         rep_valid <= 1'b0;
         rep_ok    <= 1'b0;
      end else begin
         up_go     <= 1'b0;
         down_go   <= 1'b0;
         rep_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_WAIT;
                  mask_q  <= mask_c;
                  down_go <= 1'b1;
               end else if (accept) begin
                  up_go   <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (done_next || expire) begin
                  state     <= ST_IDLE;
                  rep_valid <= 1'b1;
                  rep_ok    <= done_next && !nak_next;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_one_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_go && down_go));
   assert_mask_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      down_go |-> (down_mask != 4'b0000));
   assert_busy_on_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      down_go |-> !bc_ready);
   assert_reply_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |=> !rep_valid);
   assert_ready_at_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |-> bc_ready);
endmodule

// File: tb/tb_bcast_combiner.sv
module tb_bcast_combiner;
   localparam int ID_W  = 8;
   localparam int LEVEL = 2;
   localparam int TMO   = 32;
   localparam int ERR_W = 8;
   localparam int SPAN  = 16;
   localparam int QTR   = 4;
   localparam int EMAX  = 255;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [ID_W-1:0] sub_base = '0;
   logic            bc_valid = 1'b0;
   logic [ID_W-1:0] bc_lo = '0, bc_hi = '0;
   logic            bc_ready, up_go, down_go, rep_valid, rep_ok;
   logic [3:0]      down_mask;
   logic [3:0]      ack_vld = '0, ack_ok = '0;
   logic [ERR_W-1:0] err_cnt;

   int tests = 0, fails = 0, cycles = 0, exp_err = 0;
   int dly[4];
   int mode[4];   // 0 ok, 1 nak, 2 silent
   bit dup[4];
   bit stray_en = 1'b0, hold_en = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bcast_combiner #(.ID_W(ID_W), .LEVEL(LEVEL), .TMO(TMO), .ERR_W(ERR_W)) dut (
      .clk(clk), .rst_n(rst_n), .sub_base(sub_base), .bc_valid(bc_valid),
      .bc_lo(bc_lo), .bc_hi(bc_hi), .bc_ready(bc_ready), .up_go(up_go),
      .down_go(down_go), .down_mask(down_mask), .ack_vld(ack_vld),
      .ack_ok(ack_ok), .rep_valid(rep_valid), .rep_ok(rep_ok), .err_cnt(err_cnt)
   );

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit f_cov(int b, int lo, int hi);
      return (lo <= hi) && (lo >= b) && (hi <= b + SPAN - 1);
   endfunction

   function automatic int f_mask(int b, int lo, int hi);
      int m = 0;
      for (int i = 0; i < 4; i++) begin
         int pl = b + i * QTR;
         if (lo <= hi && lo <= pl + QTR - 1 && hi >= pl) m |= (1 << i);
      end
      return m;
   endfunction

   // presents one request at the current falling edge; returns expected mask or -1
   task automatic send_bc(int lo, int hi, output int m);
      bit cov;
      chk("R9 ready before request", int'(bc_ready), 1);
      bc_valid = 1'b1; bc_lo = ID_W'(lo); bc_hi = ID_W'(hi); ack_vld = '0;
      @(negedge clk);
      bc_valid = 1'b0;
      cov = f_cov(int'(sub_base), lo, hi);
      chk("R2 up_go", int'(up_go), int'(!cov));
      chk("R2 down_go", int'(down_go), int'(cov));
      chk("R4 ready after accept", int'(bc_ready), int'(!cov));
      if (cov) begin
         m = f_mask(int'(sub_base), lo, hi);
         chk("R3 down_mask", int'(down_mask), m);
      end else m = -1;
   endtask

   task automatic run_wait(int m);
      int  rcv = 0;
      bit  nak = 1'b0, exp_rep = 1'b0, exp_ok = 1'b0;
      for (int c = 0; c <= TMO + 2; c++) begin
         if (c > 0) @(negedge clk);
         chk("R5 rep_valid", int'(rep_valid), int'(exp_rep));
         chk("R8 err_cnt", int'(err_cnt), exp_err);
         if (exp_rep) begin
            chk("R5 R6 R7 rep_ok", int'(rep_ok), int'(exp_ok));
            chk("R9 ready in reply cycle", int'(bc_ready), 1);
            ack_vld = '0; bc_valid = 1'b0;
            return;
         end
         chk("R4 ready while pending", int'(bc_ready), 0);
         if (hold_en && c > 0) begin
            chk("R4 no up_go while pending", int'(up_go), 0);
            chk("R4 no down_go while pending", int'(down_go), 0);
         end
         ack_vld = '0; ack_ok = '0;
         for (int i = 0; i < 4; i++) begin
            if (m[i] && mode[i] != 2 && (c == dly[i] || (dup[i] && c == dly[i] + 1))) begin
               ack_vld[i] = 1'b1;
               ack_ok[i]  = (c == dly[i]) ? (mode[i] == 0) : 1'($urandom % 2);
            end else if (!m[i] && stray_en && ($urandom % 6) == 0) begin
               ack_vld[i] = 1'b1;
               ack_ok[i]  = 1'($urandom % 2);
            end
         end
         for (int i = 0; i < 4; i++) begin
            if (ack_vld[i]) begin
               if (m[i] && !rcv[i]) begin
                  rcv |= (1 << i);
                  if (!ack_ok[i]) nak = 1'b1;
               end else if (exp_err < EMAX) exp_err++;
            end
         end
         exp_rep = (rcv == m) || (c == TMO - 1);
         exp_ok  = (rcv == m) && !nak;
         if (hold_en) begin
            bc_valid = 1'b1;
            bc_lo = sub_base; bc_hi = sub_base + 8'd1;
         end
      end
      chk("R7 reply missing", 0, 1);
   endtask

   task automatic set_ports(int d, int md);
      for (int i = 0; i < 4; i++) begin
         dly[i] = d + i; mode[i] = md; dup[i] = 1'b0;
      end
   endtask

   task automatic do_bc(int lo, int hi);
      int m;
      send_bc(lo, hi, m);
      if (m >= 0) run_wait(m);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin : main
      int seed_dummy;
      seed_dummy = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", int'(bc_ready), 1);
      chk("R1 up_go", int'(up_go), 0);
      chk("R1 down_go", int'(down_go), 0);
      chk("R1 rep_valid", int'(rep_valid), 0);
      chk("R1 err_cnt", int'(err_cnt), 0);

      sub_base = 8'h40;
      @(negedge clk);
      set_ports(0, 0);                 do_bc(8'h41, 8'h4E);   // R3 all four, R5 success
      set_ports(1, 0); mode[1] = 1;    do_bc(8'h45, 8'h46);   // R6 single negative
      do_bc(8'h3F, 8'h42);                                     // R2 range leaks below
      do_bc(8'h48, 8'h44);                                     // R2 lo > hi
      do_bc(8'h4C, 8'h50);                                     // R2 range leaks above
      set_ports(0, 0); dly[2] = TMO - 1; do_bc(8'h48, 8'h4B); // R7 last reply at boundary
      set_ports(0, 0); mode[3] = 2;      do_bc(8'h44, 8'h4F); // R7 timeout
      set_ports(2, 0); hold_en = 1'b1;   do_bc(8'h40, 8'h4F); // R4 held request
      hold_en = 1'b0;
      set_ports(1, 0); dup[0] = 1'b1; dup[1] = 1'b1; stray_en = 1'b1;
      do_bc(8'h40, 8'h47);                                     // R8 duplicates and strays

      for (int n = 0; n < 150; n++) begin
         int b, lo, hi;
         b  = int'($urandom % 256) & 8'hF0;
         sub_base = ID_W'(b);
         lo = (b + int'($urandom % 24) - 4) & 8'hFF;
         hi = lo + int'($urandom % 12);
         if (hi > 255) hi = 255;
         if (($urandom % 8) == 0) begin int t = lo; lo = hi; hi = t; end
         for (int i = 0; i < 4; i++) begin
            dly[i]  = int'($urandom % 6);
            mode[i] = (($urandom % 12) == 0) ? 1 : ((($urandom % 20) == 0) ? 2 : 0);
            dup[i]  = (($urandom % 4) == 0);
         end
         stray_en = (($urandom % 2) == 0);
         do_bc(lo, hi);
      end

      stray_en = 1'b0;
      ack_vld = 4'hF;                                          // R8 saturation while idle
      for (int k = 0; k < 70; k++) begin
         @(negedge clk);
         exp_err = (exp_err + 4 > EMAX) ? EMAX : exp_err + 4;
      end
      ack_vld = '0;
      @(negedge clk);
      chk("R8 err_cnt saturates", int'(err_cnt), EMAX);
      chk("R8 idle replies give no reply", int'(rep_valid), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule